// File: doc/BRIEF.md
# Sampled Acquisition Memory Sequencer

This block is a hardware capture engine. It sits between a sampling timer, a sample-and-hold stage, an A/D converter and an external word memory, and it steps through that memory without the host touching each sample. In capture mode, every accepted timer tick starts a fixed-length hold window and pulses the converter's start line. Each converter completion strobe selects the memory, which is held in write direction, so the converted word lands at the current address. A few clock cycles later the address advances by one and the remaining-sample count drops by one.

In readout mode the memory is held in read direction. Every host strobe selects the memory once, so one stored word appears on the memory data lines. After the same fixed delay the address advances. Both modes start from address zero with a sample count loaded at the start. When that count is used up, a sticky done flag rises and the block goes idle. The address counter only moves on the delayed copy of a memory access and never on the raw timer tick. A tick that arrives before the previous sample has finished is dropped and recorded in a sticky overrun flag.

Top module: `acq_mem_seq`

## Requirements
- R1: After reset: conv_start, hold, mem_cs, done and overrun are 0, mem_rw is 1 (read) and mem_addr is 0.
- R2: In capture mode, when no sample is in flight, a tick gives a one-cycle conv_start pulse in the next cycle. hold goes high in that same cycle and stays high for exactly HOLD_CYC = CLK_HZ*HOLD_NS/1e9 cycles (at least 1).
- R3: In capture mode, a conv_done while a conversion is awaited gives a one-cycle mem_cs pulse in the next cycle, with mem_rw at 0 and mem_addr unchanged.
- R4: mem_addr rises by exactly 1, INC_DLY cycles after the cycle in which mem_cs is high. The remaining count drops by 1 at the same time.
- R5: start_acq clears mem_addr to 0, drives mem_rw to 0, loads sample_count, clears done and overrun, and enters capture mode. If start_acq and start_ret are high together, start_acq wins.
- R6: start_ret clears mem_addr to 0, drives mem_rw to 1, loads sample_count, clears done and overrun, and enters readout mode.
- R7: In readout mode, a host_rd while no increment is pending gives a one-cycle mem_cs pulse in the next cycle with mem_rw at 1. host_rd strobes that arrive while an increment is pending are ignored.
- R8: In capture mode, a tick is ignored if it arrives between an accepted tick and the address increment that ends that sample. Such a tick sets overrun, which stays at 1 until the next mode start.
- R9: Inputs from the other mode are ignored: host_rd in capture mode, and tick and conv_done in readout mode. A conv_done with no conversion awaited, and every strobe while idle, are also ignored.
- R10: done rises in the cycle of the increment that uses up the loaded count, and the block goes idle. done stays at 1 until the next mode start. A start with sample_count 0 raises done in the next cycle.
- R11: mem_addr counts modulo 2^ADDR_W, so it wraps from all-ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_acq | input | 1 | One-cycle pulse that begins capture mode |
| start_ret | input | 1 | One-cycle pulse that begins readout mode |
| sample_count | input | CNT_W | Number of words to capture or read, sampled at a start pulse |
| tick | input | 1 | Sampling timer pulse |
| conv_done | input | 1 | Converter completion strobe |
| host_rd | input | 1 | Host read strobe for readout mode |
| conv_start | output | 1 | Start-conversion pulse to the converter |
| hold | output | 1 | Sample-and-hold control, 1 = hold |
| mem_cs | output | 1 | Memory chip-select pulse |
| mem_rw | output | 1 | Memory direction, 1 = read, 0 = write |
| mem_addr | output | ADDR_W | Memory word address |
| done | output | 1 | Sticky completion flag |
| overrun | output | 1 | Sticky flag for a dropped tick |

## Verification
The bench builds the block with CLK_HZ of 1 MHz and HOLD_NS of 5000, which gives a 5-cycle hold window whose trailing edge it can see. It uses INC_DLY of 3, so a second strobe and a stray tick can be placed inside the pending window. ADDR_W of 4 with a 6-bit count lets a 20-sample capture run past the top of the address space and show the wrap. Each cycle, a behavioural model predicts every output while capture, readout, overrun, ignored strobes, a zero-length start and a simultaneous start pair are driven.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CAP  = 2'd1,
    MODE_READ = 2'd2
  } seq_mode_e;

  // Hold window length in clock cycles, never less than one.
  function automatic int unsigned hold_cycles(input longint unsigned clk_hz,
                                              input longint unsigned win_ns);
    longint unsigned c;
    c = (clk_hz * win_ns) / 64'd1000000000;
    if (c < 64'd1) c = 64'd1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/seq_one_shot.sv
module seq_one_shot #(
  parameter int unsigned LEN = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic trig,
  output logic q
);
  localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      left_q <= '0;
      q      <= 1'b0;
    end else if (trig) begin
      left_q <= CW'(LEN - 1);
      q      <= 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      q <= 1'b0;
    end
  end

  // R2: the window never extends past its loaded length
  a_r2_window_bounded: assert property (@(posedge clk) disable iff (rst)
    (!q) |-> (left_q == '0));

endmodule

// File: rtl/seq_step_delay.sv
module seq_step_delay #(
  parameter int unsigned DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic arm,
  output logic pending,
  output logic fire
);
  localparam int unsigned CW = (DLY < 2) ? 1 : $clog2(DLY + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pending <= 1'b0;
      cnt_q   <= '0;
    end else if (arm) begin
      pending <= 1'b1;
      cnt_q   <= CW'(DLY - 1);
    end else if (pending) begin
      if (cnt_q == '0) pending <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign fire = pending && (cnt_q == '0);

  // R7: a new access is never armed on top of a pending one
  a_r7_no_rearm: assert property (@(posedge clk) disable iff (rst)
    arm |-> !pending);

endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned CNT_W  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  remaining
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr      <= '0;
      remaining <= '0;
    end else if (load) begin
      addr      <= '0;
      remaining <= load_val;
    end else if (step) begin
      addr      <= addr + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end

  // R4: the count never steps below zero
  a_r4_step_has_budget: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |-> (remaining != '0));

endmodule

// File: rtl/acq_mem_seq.sv
module acq_mem_seq
  import acq_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned HOLD_NS = 10_000,
  parameter int unsigned INC_DLY = 2,
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned CNT_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_acq,
  input  logic              start_ret,
  input  logic [CNT_W-1:0]  sample_count,
  input  logic              tick,
  input  logic              conv_done,
  input  logic              host_rd,
  output logic              conv_start,
  output logic              hold,
  output logic              mem_cs,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done,
  output logic              overrun
);
  localparam int unsigned HOLD_CYC = hold_cycles(longint'(CLK_HZ), longint'(HOLD_NS));
  localparam int unsigned STEP_DLY = (INC_DLY < 1) ? 1 : INC_DLY;

  seq_mode_e        mode_q;
  logic             wait_q;
  logic             start_any;
  logic             count_zero;
  logic             in_cap, in_read;
  logic             pend, fire, step;
  logic             busy;
  logic             take_tick, drop_tick, take_done, take_rd, arm;
  logic             finish;
  logic [CNT_W-1:0] remaining;

  assign start_any  = start_acq | start_ret;
  assign count_zero = (sample_count == '0);
  assign in_cap     = (mode_q == MODE_CAP);
  assign in_read    = (mode_q == MODE_READ);
  assign busy       = wait_q | pend;

  assign take_tick = !start_any && in_cap && tick && !busy;
  assign drop_tick = !start_any && in_cap && tick && busy;
  assign take_done = !start_any && in_cap && conv_done && wait_q;
  assign take_rd   = !start_any && in_read && host_rd && !pend;
  assign arm       = take_done | take_rd;
  assign step      = fire && !start_any;
  assign finish    = step && (remaining == CNT_W'(1));

  seq_one_shot #(.LEN(HOLD_CYC)) i_hold (
    .clk (clk),
    .rst (rst),
    .clr (start_any),
    .trig(take_tick),
    .q   (hold)
  );

  seq_step_delay #(.DLY(STEP_DLY)) i_delay (
    .clk    (clk),
    .rst    (rst),
    .clr    (start_any),
    .arm    (arm),
    .pending(pend),
    .fire   (fire)
  );

  seq_addr_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (start_any),
    .load_val (sample_count),
    .step     (step),
    .addr     (mem_addr),
    .remaining(remaining)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_IDLE;
      mem_rw     <= 1'b1;
      done       <= 1'b0;
      overrun    <= 1'b0;
      wait_q     <= 1'b0;
      mem_cs     <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      mem_cs     <= arm;
      conv_start <= take_tick;
      if (start_any) begin
        if (count_zero)     mode_q <= MODE_IDLE;
        else if (start_acq) mode_q <= MODE_CAP;
        else                mode_q <= MODE_READ;
        mem_rw  <= ~start_acq;
        done    <= count_zero;
        overrun <= 1'b0;
        wait_q  <= 1'b0;
      end else begin
        if (finish) begin
          mode_q <= MODE_IDLE;
          done   <= 1'b1;
        end
        if (drop_tick) overrun <= 1'b1;
        if (take_tick)      wait_q <= 1'b1;
        else if (take_done) wait_q <= 1'b0;
      end
    end
  end

  // R2: a conversion is only started with the hold window open
  a_r2_start_in_hold: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> hold);

  // R3: a write select follows a converter strobe
  a_r3_write_cs_cause: assert property (@(posedge clk) disable iff (rst)
    (mem_cs && !mem_rw) |-> $past(conv_done));

  // R7: a read select follows a host strobe
  a_r7_read_cs_cause: assert property (@(posedge clk) disable iff (rst)
    (mem_cs && mem_rw) |-> $past(host_rd));

  // R4: outside a start the address only moves up by one
  a_r4_addr_single_step: assert property (@(posedge clk) disable iff (rst)
    ((mem_addr != $past(mem_addr)) && !$past(start_any))
      |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R5: direction changes only at a mode start
  a_r5_rw_held: assert property (@(posedge clk) disable iff (rst)
    !start_any |=> $stable(mem_rw));

  // R10: done stays up until a new start
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !start_any) |=> done);

  // R8: overrun stays up until a new start
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !start_any) |=> overrun);

endmodule

// File: tb/test_acq_mem_seq.sv
module test_acq_mem_seq;
  localparam int unsigned CLK_HZ  = 1_000_000;
  localparam int unsigned HOLD_NS = 5000;
  localparam int          HOLD    = 5;
  localparam int unsigned INC_DLY = 3;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned CNT_W   = 6;
  localparam int          DEPTH   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_acq = 1'b0, start_ret = 1'b0;
  logic [CNT_W-1:0] sample_count = '0;
  logic tick = 1'b0, conv_done = 1'b0, host_rd = 1'b0;
  logic conv_start, hold, mem_cs, mem_rw, done, overrun;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  acq_mem_seq #(
    .CLK_HZ(CLK_HZ), .HOLD_NS(HOLD_NS), .INC_DLY(INC_DLY),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) i_acq_mem_seq (
    .clk(clk), .rst(rst), .start_acq(start_acq), .start_ret(start_ret),
    .sample_count(sample_count), .tick(tick), .conv_done(conv_done),
    .host_rd(host_rd), .conv_start(conv_start), .hold(hold), .mem_cs(mem_cs),
    .mem_rw(mem_rw), .mem_addr(mem_addr), .done(done), .overrun(overrun)
  );

  // Behavioural reference: 0 idle, 1 capture, 2 readout
  int m_mode = 0, m_addr = 0, m_rem = 0, m_hold = 0, m_inc = 0;
  bit m_rw = 1, m_wait = 0, m_cs = 0, m_cst = 0, m_done = 0, m_ovr = 0;

  always @(posedge clk) begin
    bit busy;
    int pmode;
    busy  = m_wait || (m_inc > 0);
    pmode = m_mode;
    if (rst) begin
      m_mode = 0; m_addr = 0; m_rem = 0; m_hold = 0; m_inc = 0;
      m_rw = 1; m_wait = 0; m_cs = 0; m_cst = 0; m_done = 0; m_ovr = 0;
    end else begin
      m_cs = 0; m_cst = 0;
      if (m_hold > 0) m_hold--;
      if (start_acq || start_ret) begin
        m_rem  = int'(sample_count);
        m_mode = (m_rem == 0) ? 0 : (start_acq ? 1 : 2);
        m_rw   = !start_acq;
        m_addr = 0; m_done = (m_rem == 0); m_ovr = 0;
        m_hold = 0; m_inc = 0; m_wait = 0;
      end else begin
        if (m_inc > 0) begin
          m_inc--;
          if (m_inc == 0) begin
            m_addr = (m_addr + 1) % DEPTH;
            m_rem--;
            if (m_rem == 0) begin m_done = 1; m_mode = 0; end
          end
        end
        if (pmode == 1 && tick) begin
          if (busy) m_ovr = 1;
          else begin m_cst = 1; m_hold = HOLD; m_wait = 1; end
        end
        if (pmode == 1 && conv_done && m_wait && !m_cst) begin
          m_cs = 1; m_wait = 0; m_inc = INC_DLY;
        end
        if (pmode == 2 && host_rd && !busy) begin
          m_cs = 1; m_inc = INC_DLY;
        end
      end
    end
  end

  task automatic cmp(string sig, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", phase, sig, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("conv_start", int'(conv_start), int'(m_cst));
    cmp("hold",       int'(hold),       (m_hold > 0) ? 1 : 0);
    cmp("mem_cs",     int'(mem_cs),     int'(m_cs));
    cmp("mem_rw",     int'(mem_rw),     int'(m_rw));
    cmp("mem_addr",   int'(mem_addr),   m_addr);
    cmp("done",       int'(done),       int'(m_done));
    cmp("overrun",    int'(overrun),    int'(m_ovr));
  end

  // Fixed expectations straight from the requirements
  task automatic expect_eq(string rq, string sig, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d (directed)", rq, sig, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(bit t, bit cd, bit hr, bit sa, bit sr);
    tick = t; conv_done = cd; host_rd = hr; start_acq = sa; start_ret = sr;
    @(negedge clk);
    tick = 0; conv_done = 0; host_rd = 0; start_acq = 0; start_ret = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(2);
    expect_eq("R1", "mem_rw", int'(mem_rw), 1);
    expect_eq("R1", "mem_addr", int'(mem_addr), 0);
    expect_eq("R1", "done", int'(done), 0);
    rst = 0;
    idle(2);

    // Capture of three samples
    phase = "R5";
    sample_count = 6'd3;
    drive(0, 0, 0, 1, 0);
    expect_eq("R5", "mem_rw", int'(mem_rw), 0);
    phase = "R2,R3,R4";
    drive(1, 0, 0, 0, 0);
    expect_eq("R2", "conv_start", int'(conv_start), 1);
    idle(1);
    drive(0, 1, 0, 0, 0);
    expect_eq("R3", "mem_cs", int'(mem_cs), 1);
    idle(6);
    expect_eq("R4", "mem_addr", int'(mem_addr), 1);

    phase = "R8";
    drive(1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0);
    drive(1, 0, 0, 0, 0);
    idle(5);
    expect_eq("R8", "overrun", int'(overrun), 1);

    phase = "R9";
    drive(0, 0, 1, 0, 0);
    drive(0, 1, 0, 0, 0);
    idle(4);
    expect_eq("R9", "mem_addr", int'(mem_addr), 2);

    phase = "R10";
    drive(1, 0, 0, 0, 0);
    idle(2);
    drive(0, 1, 0, 0, 0);
    idle(6);
    expect_eq("R10", "done", int'(done), 1);
    expect_eq("R10", "mem_addr", int'(mem_addr), 3);
    drive(1, 1, 1, 0, 0);
    idle(3);
    expect_eq("R10", "done_sticky", int'(done), 1);

    // Capture that runs past the top of the address space
    phase = "R11";
    sample_count = 6'd20;
    drive(0, 0, 0, 1, 0);
    for (int i = 0; i < 20; i++) begin
      drive(1, 0, 0, 0, 0);
      idle(1);
      drive(0, 1, 0, 0, 0);
      idle(4);
    end
    idle(2);
    expect_eq("R11", "mem_addr", int'(mem_addr), 4);
    expect_eq("R11", "overrun", int'(overrun), 0);

    // Readout of five words
    phase = "R6";
    sample_count = 6'd5;
    drive(0, 0, 0, 0, 1);
    expect_eq("R6", "mem_rw", int'(mem_rw), 1);
    expect_eq("R6", "mem_addr", int'(mem_addr), 0);
    expect_eq("R6", "done", int'(done), 0);
    phase = "R7";
    for (int i = 0; i < 5; i++) begin
      drive(0, 0, 1, 0, 0);
      drive(0, 0, 1, 0, 0);
      if (i == 2) begin
        phase = "R9";
        drive(1, 1, 0, 0, 0);
        phase = "R7";
      end else idle(1);
      idle(3);
    end
    expect_eq("R7", "mem_addr", int'(mem_addr), 5);
    expect_eq("R10", "done", int'(done), 1);
    expect_eq("R9", "overrun", int'(overrun), 0);

    // Zero-length start
    phase = "R10";
    sample_count = 6'd0;
    drive(0, 0, 0, 1, 0);
    expect_eq("R10", "done_zero", int'(done), 1);
    drive(1, 0, 0, 0, 0);
    expect_eq("R9", "conv_start_idle", int'(conv_start), 0);

    // Both starts together
    phase = "R5";
    sample_count = 6'd2;
    drive(0, 0, 0, 1, 1);
    expect_eq("R5", "mem_rw_both", int'(mem_rw), 0);
    for (int i = 0; i < 2; i++) begin
      drive(1, 0, 0, 0, 0);
      drive(0, 1, 0, 0, 0);
      idle(5);
    end
    expect_eq("R5", "mem_addr_both", int'(mem_addr), 2);
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule